// File: doc/BRIEF.md
# Acknowledge Polling Sequencer

After a serial EEPROM has been given the stop that ends a write, it spends a self-timed interval programming its array and does not respond on the bus during that time. This sequencer finds the end of that interval by probing the device instead of waiting a fixed worst-case delay. It does not generate SCL or SDA itself. It drives a byte-level two-wire master through three commands: start, write one byte and report whether it was acknowledged, and stop. Each command is offered with a valid/ready handshake, and the master answers each accepted command with one response strobe.

A probe is a start followed by the device address byte, which is built from the 1010 type prefix, a 3-bit select, and a write bit of 0. If the probe gets no acknowledge, the sequencer sends a stop and probes again. If the device acknowledges, the next step depends on the operation that follows. When that operation is a write, the sequencer sends the word address at once and leaves the bus open, so the write data can follow without a stop. When it is a read, the sequencer sends a stop and releases the bus. A parameter caps the number of probes. When the cap is reached without an acknowledge, the sequencer reports a timeout and returns to idle.

States are `S_IDLE`, `S_START`/`S_START_W` (issue start, await response), `S_PROBE`/`S_PROBE_W` (address byte), `S_RETRY_STOP`/`S_RETRY_STOP_W` (stop after a miss), `S_WORD`/`S_WORD_W` (word address) and `S_FINAL_STOP`/`S_FINAL_STOP_W` (stop before a read). The transitions are:

- idle to start, on a request.
- Each issue state to its wait state, on handshake.
- Start-wait to probe.
- Probe-wait to one of three states:
  - word, on acknowledge with a write next;
  - final-stop, on acknowledge with a read next;
  - retry-stop, on a miss.
- Retry-stop-wait to idle when the cap is reached, and to start otherwise.
- Word-wait and final-stop-wait to idle.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy_o`, `cmd_valid_o`, `done_o` and `timeout_o` are all 0.
- R2: A request on `start_i` starts a probe. The probe is a start command (`cmd_op_o` = 2'b00), then a write command (`cmd_op_o` = 2'b01) whose byte is {4'b1010, `dev_sel_i`, 1'b0}.
- R3: When the address byte is not acknowledged, the next command is a stop (`cmd_op_o` = 2'b10), and then a new probe begins with a start.
- R4: When the address byte is acknowledged and `next_write_i` was 1, the next command writes `word_addr_i`. No stop is issued, and `done_o` pulses once after that byte's response.
- R5: When the address byte is acknowledged and `next_write_i` was 0, the next command is a stop, and `done_o` pulses once after its response.
- R6: After MAX_POLLS probes that all go unacknowledged, the sequencer issues the final stop, pulses `timeout_o` once, returns to idle, and does not pulse `done_o`.
- R7: An acknowledge on probe number MAX_POLLS ends in success (`done_o`), not in a timeout.
- R8: A command is accepted only in a cycle where `cmd_valid_o` and `cmd_ready_i` are both 1. While `cmd_ready_i` is 0, the offered command and its byte stay unchanged, and each command appears exactly once on the bus.
- R9: `start_i` has no effect while busy. Select, word address and next-operation type are captured at the accepted request and used for the whole run.
- R10: `done_o` and `timeout_o` are single-cycle pulses and never high together. Each return to idle is marked by exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin polling (sampled when idle) |
| next_write_i | input | 1 | 1 if the following operation is a write |
| dev_sel_i | input | 3 | Device select bits of the address byte |
| word_addr_i | input | 8 | Word address sent before a following write |
| cmd_ready_i | input | 1 | Byte master can accept a command |
| rsp_valid_i | input | 1 | Byte master finished the accepted command |
| rsp_ack_i | input | 1 | Acknowledge seen for a write command |
| cmd_valid_o | output | 1 | Command offered |
| cmd_op_o | output | 2 | 00 start, 01 write byte, 10 stop |
| cmd_byte_o | output | 8 | Byte for a write command |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | Success pulse |
| timeout_o | output | 1 | Probe limit reached pulse |

## Verification
Two functions can resolve in the same response cycle: success, and exhaustion of the probe limit. When the acknowledge arrives on the very probe that brings the counter to its limit, both conditions are true at once. The bench provokes this by having the modelled byte master refuse exactly MAX_POLLS-1 address bytes and then acknowledge one. It judges the outcome by the whole logged command sequence, which must end with a stop and no extra probe, and by seeing one `done_o` pulse and no `timeout_o`. It also runs one more refusal than that, which must give exactly one timeout, and it repeats a run with the ready line toggling so that commands wait in their issue states.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_WRITE = 2'b01,
        OP_STOP  = 2'b10
    } bus_op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_START_W,
        S_PROBE,
        S_PROBE_W,
        S_RETRY_STOP,
        S_RETRY_STOP_W,
        S_WORD,
        S_WORD_W,
        S_FINAL_STOP,
        S_FINAL_STOP_W
    } seq_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         SEL_W    = 3;
    localparam int         BYTE_W   = 8;

endpackage

// File: rtl/poll_dev_byte.sv
module poll_dev_byte
    import poll_pkg::*;
#(
    parameter logic [3:0] PREFIX = DEV_TYPE
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] byte_o
);

    // type prefix in the upper nibble, select next, direction bit last
    assign byte_o = {PREFIX, sel_i, rd_i};

endmodule

// File: rtl/poll_attempt_ctr.sv
module poll_attempt_ctr #(
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);

    localparam int            CW    = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign at_limit_o = (cnt_q == LIMIT);

    // R6: the attempt count never passes the configured cap
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R6: each counted probe raises the count by exactly one
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
    import poll_pkg::*;
#(
    parameter int MAX_POLLS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              next_write_i,
    input  logic [SEL_W-1:0]  dev_sel_i,
    input  logic [BYTE_W-1:0] word_addr_i,
    input  logic              cmd_ready_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_ack_i,
    output logic              cmd_valid_o,
    output logic [1:0]        cmd_op_o,
    output logic [BYTE_W-1:0] cmd_byte_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);

    seq_state_t        state_q;
    logic              wr_next_q;
    logic [SEL_W-1:0]  sel_q;
    logic [BYTE_W-1:0] word_q;
    logic              done_q;
    logic              timeout_q;
    logic [BYTE_W-1:0] dev_byte;
    logic              at_limit;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              fire;

    poll_dev_byte u_dev_byte (
        .sel_i  (sel_q),
        .rd_i   (1'b0),
        .byte_o (dev_byte)
    );

    assign fire    = cmd_valid_o && cmd_ready_i;
    assign cnt_clr = (state_q == S_IDLE) && start_i;
    assign cnt_inc = (state_q == S_PROBE) && fire;

    poll_attempt_ctr #(.MAX_POLLS(MAX_POLLS)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cnt_clr),
        .inc_i      (cnt_inc),
        .at_limit_o (at_limit)
    );

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            wr_next_q <= 1'b0;
            sel_q     <= '0;
            word_q    <= '0;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        wr_next_q <= next_write_i;
                        sel_q     <= dev_sel_i;
                        word_q    <= word_addr_i;
                        state_q   <= S_START;
                    end
                end
                S_START:        if (fire) state_q <= S_START_W;
                S_START_W:      if (rsp_valid_i) state_q <= S_PROBE;
                S_PROBE:        if (fire) state_q <= S_PROBE_W;
                S_PROBE_W: begin
                    if (rsp_valid_i) begin
                        if (!rsp_ack_i)    state_q <= S_RETRY_STOP;
                        else if (wr_next_q) state_q <= S_WORD;
                        else               state_q <= S_FINAL_STOP;
                    end
                end
                S_RETRY_STOP:   if (fire) state_q <= S_RETRY_STOP_W;
                S_RETRY_STOP_W: begin
                    if (rsp_valid_i) begin
                        if (at_limit) begin
                            timeout_q <= 1'b1;
                            state_q   <= S_IDLE;
                        end else begin
                            state_q   <= S_START;
                        end
                    end
                end
                S_WORD:         if (fire) state_q <= S_WORD_W;
                S_WORD_W: begin
                    if (rsp_valid_i) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                S_FINAL_STOP:   if (fire) state_q <= S_FINAL_STOP_W;
                S_FINAL_STOP_W: begin
                    if (rsp_valid_i) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default:        state_q <= S_IDLE;
            endcase
        end
    end

    // command outputs decoded from state
    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_op_o    = OP_START;
        cmd_byte_o  = '0;
        unique case (state_q)
            S_START: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_START;
            end
            S_PROBE: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_WRITE;
                cmd_byte_o  = dev_byte;
            end
            S_RETRY_STOP, S_FINAL_STOP: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_STOP;
            end
            S_WORD: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_WRITE;
                cmd_byte_o  = word_q;
            end
            default: ;
        endcase
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;
    assign timeout_o = timeout_q;

    // R8: an offered command waits unchanged until it is taken
    p_hold_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o)));

    // R10: completion flags are single pulses and mutually exclusive
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_timeout_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    // R10: every return to idle carries exactly one outcome flag
    p_end_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o ^ timeout_o));

    // R6: a timeout only follows a stop response
    p_timeout_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> ($past(state_q) == S_RETRY_STOP_W && $past(rsp_valid_i)));

endmodule

// File: tb/tb_ack_poll_seq.sv
module tb_ack_poll_seq;
    import poll_pkg::*;

    localparam int MAXP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       next_write_i = 1'b0;
    logic [2:0] dev_sel_i = '0;
    logic [7:0] word_addr_i = '0;
    logic       cmd_ready = 1'b1;
    logic       rsp_valid = 1'b0;
    logic       rsp_ack = 1'b0;
    logic       cmd_valid_o;
    logic [1:0] cmd_op_o;
    logic [7:0] cmd_byte_o;
    logic       busy_o, done_o, timeout_o;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    int tmo_cnt = 0;
    int nak_left = 0;
    logic ready_toggle = 1'b0;
    logic [1:0] log_op [64];
    logic [7:0] log_dat [64];
    int log_n = 0;
    logic after_start = 1'b0;

    always #10 clk = ~clk;

    ack_poll_seq #(.MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_write_i(next_write_i),
        .dev_sel_i(dev_sel_i), .word_addr_i(word_addr_i), .cmd_ready_i(cmd_ready),
        .rsp_valid_i(rsp_valid), .rsp_ack_i(rsp_ack), .cmd_valid_o(cmd_valid_o),
        .cmd_op_o(cmd_op_o), .cmd_byte_o(cmd_byte_o), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o)
    );

    // outcome pulse monitor
    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (timeout_o) tmo_cnt++;
    end

    // byte-level master model: ready pattern, command log, responses
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            cmd_ready = ready_toggle ? ~cmd_ready : 1'b1;
            if (cmd_valid_o && cmd_ready && rst_n) begin
                logic a;
                a = 1'b1;
                if (log_n < 64) begin
                    log_op[log_n]  = cmd_op_o;
                    log_dat[log_n] = cmd_byte_o;
                end
                log_n++;
                if (cmd_op_o == 2'b00) after_start = 1'b1;
                else if (cmd_op_o == 2'b01 && after_start) begin
                    after_start = 1'b0;
                    if (nak_left > 0) begin
                        a = 1'b0;
                        nak_left--;
                    end
                end
                repeat (2) @(negedge clk);
                rsp_ack   = a;
                rsp_valid = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // run one polling request; optionally a second request while busy
    task automatic do_poll(input logic wr, input logic [2:0] sel, input logic [7:0] wa,
                           input int naks, input logic tog, input logic glitch);
        log_n = 0; done_cnt = 0; tmo_cnt = 0; nak_left = naks; ready_toggle = tog;
        @(negedge clk);
        next_write_i = wr; dev_sel_i = sel; word_addr_i = wa; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (glitch) begin
            repeat (5) @(negedge clk);
            next_write_i = ~wr; dev_sel_i = ~sel; word_addr_i = ~wa; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (6) @(negedge clk);
        ready_toggle = 1'b0;
    endtask

    // compare the logged commands against the sequence the requirements give
    task automatic check_log(input string req, input logic wr, input logic [2:0] sel,
                             input logic [7:0] wa, input int naks);
        logic [1:0] eo [64];
        logic [7:0] ed [64];
        int n = 0;
        int bad = -1;
        int tries = (naks < MAXP) ? naks : MAXP;
        for (int i = 0; i < tries; i++) begin
            eo[n] = 2'b00; ed[n] = 8'h00; n++;
            eo[n] = 2'b01; ed[n] = {4'b1010, sel, 1'b0}; n++;
            eo[n] = 2'b10; ed[n] = 8'h00; n++;
        end
        if (naks < MAXP) begin
            eo[n] = 2'b00; ed[n] = 8'h00; n++;
            eo[n] = 2'b01; ed[n] = {4'b1010, sel, 1'b0}; n++;
            if (wr) begin eo[n] = 2'b01; ed[n] = wa; end
            else    begin eo[n] = 2'b10; ed[n] = 8'h00; end
            n++;
        end
        chk(log_n == n, req, "command count", log_n, n);
        for (int i = 0; i < n && i < log_n; i++) begin
            if (bad < 0 && (log_op[i] != eo[i] ||
                (eo[i] == 2'b01 && log_dat[i] != ed[i]))) bad = i;
        end
        if (bad >= 0)
            chk(1'b0, req, "command op/byte at index", {22'd0, log_op[bad], log_dat[bad]},
                {22'd0, eo[bad], ed[bad]});
        else
            chk(1'b1, req, "sequence", 0, 0);
    endtask

    task automatic check_flags(input string req, input int d, input int t);
        chk(done_cnt == d, req, "done pulses", done_cnt, d);
        chk(tmo_cnt == t, req, "timeout pulses", tmo_cnt, t);
        chk(busy_o == 1'b0, req, "busy after end", busy_o, 0);
    endtask

    task automatic t_reset;
        chk(!busy_o && !cmd_valid_o && !done_o && !timeout_o, "R1", "idle outputs",
            {busy_o, cmd_valid_o, done_o, timeout_o}, 0);
    endtask

    task automatic t_write_after_retries;  // R2 R3 R4
        do_poll(1'b1, 3'b101, 8'h3C, 2, 1'b0, 1'b0);
        check_log("R3", 1'b1, 3'b101, 8'h3C, 2);
        check_flags("R4", 1, 0);
    endtask

    task automatic t_read_immediate;  // R2 R5
        do_poll(1'b0, 3'b010, 8'h00, 0, 1'b0, 1'b0);
        check_log("R2", 1'b0, 3'b010, 8'h00, 0);
        check_flags("R5", 1, 0);
    endtask

    task automatic t_timeout;  // R6
        do_poll(1'b0, 3'b111, 8'h00, MAXP, 1'b0, 1'b0);
        check_log("R6", 1'b0, 3'b111, 8'h00, MAXP);
        check_flags("R6", 0, 1);
    endtask

    task automatic t_last_chance;  // R7
        do_poll(1'b0, 3'b001, 8'h00, MAXP - 1, 1'b0, 1'b0);
        check_log("R7", 1'b0, 3'b001, 8'h00, MAXP - 1);
        check_flags("R7", 1, 0);
    endtask

    task automatic t_ready_gating;  // R8
        do_poll(1'b1, 3'b110, 8'hA5, 1, 1'b1, 1'b0);
        check_log("R8", 1'b1, 3'b110, 8'hA5, 1);
        check_flags("R8", 1, 0);
    endtask

    task automatic t_busy_request;  // R9
        do_poll(1'b1, 3'b011, 8'h5A, 3, 1'b0, 1'b1);
        check_log("R9", 1'b1, 3'b011, 8'h5A, 3);
        check_flags("R9", 1, 0);
        chk(log_n == 12 && !busy_o, "R9", "no rerun after idle", log_n, 12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_after_retries();
        t_read_immediate();
        t_timeout();
        t_last_chance();
        t_ready_gating();
        t_busy_request();
        // R10: one outcome per run was counted in every scenario above
        chk(done_cnt + tmo_cnt == 1, "R10", "outcome pulses last run", done_cnt + tmo_cnt, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule